// File: doc/BRIEF.md
# Programmable Down-Counting Clock Divider

The block derives a slower square-ish wave from its input clock. A small write port holds two settings: an 8-bit divide ratio and a run bit. An internal down-counter steps once per input clock while the block runs. When the counter reaches zero, it reloads the programmed ratio. The divide factor is therefore ratio + 1 input clocks. Every write of the ratio also loads the counter at once, so a new ratio starts from a known point.

The output level comes from comparing the live count with half the period. It is high while the count is at or above the ratio divided by two, rounded up, and low below that. An odd ratio therefore gives an exact 50% duty cycle. The output is a register in the input clock domain.

The block is idle when the run bit is clear or the ratio is zero. While idle the output is held at 0 and the counter holds its value. Only the programmed ratio and the run bit can be read back. The live count cannot.

Top module: `clkdiv_down`

## Requirements
- R1: A synchronous active-high reset clears the ratio, the run bit and the counter, and drives `div_out`, `rd_ratio` and `rd_run` to 0.
- R2: A write with `wr_sel`=0 stores `wr_data` as the ratio and loads the counter with the same value on that clock edge. A ratio written this way produces a high phase of floor(ratio/2)+1 clocks, starting one clock after the write.
- R3: When the run bit is 0 or the ratio is 0, `div_out` is 0 and the counter holds its value.
- R4: While running, the counter steps down by one per clock and reloads the ratio after reaching 0, so each output period is ratio+1 clocks.
- R5: While running, the output is high when the count is at least ceil(ratio/2) and low otherwise. This gives high phases of floor(ratio/2)+1 clocks and low phases of ceil(ratio/2) clocks, which are equal for an odd ratio.
- R6: `div_out` is registered and follows the count one clock later. After the run bit is set, the first level appears one clock after the enabling write and starts from the count already loaded.
- R7: A write with `wr_sel`=1 sets the run bit from `wr_data` bit 0 and leaves the ratio and the counter unchanged.
- R8: `rd_ratio` and `rd_run` show the stored ratio and run bit from the clock after the write that sets them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Target: 0 selects the ratio, 1 selects the control (bit 0 = run) |
| wr_data | input | 8 | Write data |
| rd_ratio | output | 8 | Stored ratio |
| rd_run | output | 1 | Stored run bit |
| div_out | output | 1 | Divided output, registered |

## Verification
The bench uses the default 8-bit ratio width. This covers both ends of the range: ratios 1, 2 and 3, where the phases are only one or two clocks long, and ratios 254 and 255, where the period spans 255 and 256 clocks and the reload passes through the full counter width. Separate tests cover a ratio of zero with the run bit set, a cleared run bit, the one-clock start latency, and a ratio reload while running.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned DIV_W = 8;

  typedef enum logic {
    SEL_RATIO = 1'b0,
    SEL_CTRL  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int unsigned W = DIV_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  reg_sel_e     wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ratio_q,
  output logic         run_q,
  output logic         ratio_wr,
  output logic         active
);
  logic ctrl_wr;

  assign ratio_wr = wr_en && (wr_sel == SEL_RATIO);
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= '0;
      run_q   <= 1'b0;
    end else if (ratio_wr) begin
      ratio_q <= wr_data;
    end else if (ctrl_wr) begin
      run_q <= wr_data[0];
    end
  end

  assign active = run_q && (ratio_q != '0);

  // R7: a control write leaves the ratio untouched
  p_ctrl_keeps_ratio_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> $stable(ratio_q));
  // R8: a ratio write is visible on the next clock
  p_ratio_visible_r8: assert property (@(posedge clk) disable iff (rst)
    ratio_wr |=> ratio_q == $past(wr_data));
endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic [W-1:0] ratio,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)           cnt_d = load_val;
    else if (run)       cnt_d = (cnt_q == '0) ? ratio : cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R2: a ratio write loads the counter
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val));
  // R4: step down by one while running
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4: reload at zero
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt_q == '0) |=> cnt_q == $past(ratio));
  // R3: hold while idle
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/clkdiv_shape.sv
module clkdiv_shape #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic [W-1:0] ratio,
  input  logic [W-1:0] cnt,
  output logic         out_q
);
  logic [W:0] ratio_ext;
  logic [W:0] thresh;
  logic       level;

  assign ratio_ext = {1'b0, ratio};
  assign thresh    = (ratio_ext + {{W{1'b0}}, 1'b1}) >> 1;
  assign level     = active && ({1'b0, cnt} >= thresh);

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= level;
  end

  // R5: the top of the count is always in the high phase
  p_top_high_r5: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == ratio) |=> out_q);
  // R5: the zero count is always in the low phase
  p_zero_low_r5: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == '0) |=> !out_q);
endmodule

// File: rtl/clkdiv_down.sv
module clkdiv_down
  import clkdiv_pkg::*;
#(
  parameter int unsigned W = DIV_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_ratio,
  output logic         rd_run,
  output logic         div_out
);
  reg_sel_e     sel;
  logic [W-1:0] ratio_q;
  logic         run_q;
  logic         ratio_wr;
  logic         active;
  logic [W-1:0] cnt_q;

  assign sel = reg_sel_e'(wr_sel);

  clkdiv_cfg #(.W(W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data),
    .ratio_q(ratio_q), .run_q(run_q), .ratio_wr(ratio_wr), .active(active)
  );

  clkdiv_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .load(ratio_wr), .load_val(wr_data),
    .run(active), .ratio(ratio_q), .cnt_q(cnt_q)
  );

  clkdiv_shape #(.W(W)) u_shape (
    .clk(clk), .rst(rst), .active(active), .ratio(ratio_q),
    .cnt(cnt_q), .out_q(div_out)
  );

  assign rd_ratio = ratio_q;
  assign rd_run   = run_q;

  // R1: reset clears everything visible
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!div_out && rd_ratio == '0 && !rd_run));
  // R3: idle means a low output on the next clock
  p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_q || ratio_q == '0) |=> !div_out);
  // R4: the count never exceeds the stored ratio
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= ratio_q);
endmodule

// File: tb/clkdiv_down_bench.sv
module clkdiv_down_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {ratio, expected high clocks, expected low clocks}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd1,   8'd1,   8'd1},
    {8'd2,   8'd2,   8'd1},
    {8'd3,   8'd2,   8'd2},
    {8'd254, 8'd128, 8'd127},
    {8'd255, 8'd128, 8'd128}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_ratio;
  logic       rd_run;
  logic       div_out;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_down u_clkdiv_down (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_ratio(rd_ratio), .rd_run(rd_run), .div_out(div_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(input logic sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    int guard;
    hi = 0; lo = 0; guard = 0;
    while (div_out !== 1'b0 && guard < 600) begin @(negedge clk); guard++; end
    while (div_out !== 1'b1 && guard < 1200) begin @(negedge clk); guard++; end
    while (div_out === 1'b1 && hi < 600) begin hi++; @(negedge clk); end
    while (div_out === 1'b0 && lo < 600) begin lo++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hi, lo, ones;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 div_out after reset", int'(div_out), 0);
    check("R1 rd_ratio after reset", int'(rd_ratio), 0);
    check("R1 rd_run after reset", int'(rd_run), 0);

    // Table walk: R4/R5 period and phases
    for (int i = 0; i < NVEC; i++) begin
      write(1'b1, 8'd0);
      write(1'b0, VEC[i][23:16]);
      write(1'b1, 8'd1);
      measure(hi, lo);
      check($sformatf("R5 high phase ratio %0d", VEC[i][23:16]), hi, int'(VEC[i][15:8]));
      check($sformatf("R5 low phase ratio %0d", VEC[i][23:16]), lo, int'(VEC[i][7:0]));
      check($sformatf("R4 period ratio %0d", VEC[i][23:16]), hi + lo, int'(VEC[i][23:16]) + 1);
    end

    // R3: ratio zero with run set
    write(1'b0, 8'd0);
    ones = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (div_out) ones++; end
    check("R3 ratio zero keeps output low", ones, 0);

    // R3/R7: run cleared with nonzero ratio
    write(1'b1, 8'd0);
    write(1'b0, 8'd7);
    ones = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (div_out) ones++; end
    check("R3 run clear keeps output low", ones, 0);
    check("R8 rd_ratio readback", int'(rd_ratio), 7);
    check("R8 rd_run readback", int'(rd_run), 0);

    // R6: start latency from the loaded count (ratio 5 loaded, run set)
    write(1'b0, 8'd5);
    write(1'b1, 8'd1);
    check("R6 output still low at enabling clock", int'(div_out), 0);
    @(negedge clk);
    check("R6 first level one clock later", int'(div_out), 1);
    check("R7 control write keeps ratio", int'(rd_ratio), 5);

    // R2: reload while running with ratio 9 gives 5 highs then a low
    write(1'b0, 8'd9);
    hi = 0;
    @(negedge clk);
    while (div_out === 1'b1 && hi < 20) begin hi++; @(negedge clk); end
    check("R2 high phase after ratio write", hi, 5);
    check("R2 low follows high after ratio write", int'(div_out), 0);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 div_out after mid-run reset", int'(div_out), 0);
    check("R1 rd_run after mid-run reset", int'(rd_run), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule